// File: doc/BRIEF.md
# Interrupt Aggregator with Idle Wakeup Gating

This block gathers up to 32 level-sensitive peripheral interrupt lines into two requests. Each line first passes through a synchronizer. The synchronized levels form a read-only status word. A mask word selects which sources raise the core interrupt request. A separate wakeup-enable word selects which sources may ask the power-management unit to wake the core. The wakeup request is only raised while the core reports that it is idle.

The two paths are independent. A source whose mask bit is clear but whose wakeup-enable bit is set can still wake an idle core. It never raises the interrupt request. Software reaches the three words through a simple single-cycle register port with a write strobe. Reads are combinational on the address.

Top module: `irq_wake_agg`

## Requirements
- R1: After reset the mask word reads 0, the wakeup-enable word reads 1 in every implemented bit, the status word reads 0, and both requests are low.
- R2: The status word at byte offset 4 reads bit i as the level of source input i, delayed by two clock edges. Writes to offset 4 leave it unchanged.
- R3: The interrupt request is high exactly when some status bit and the mask bit at the same position (offset 0) are both 1.
- R4: The wakeup request is a register. After a clock edge it is high exactly when, before that edge, the idle input was high and some status bit and the wakeup-enable bit at the same position (offset 8) were both 1.
- R5: While the idle input is low, the wakeup request is low after the next edge, whatever the wakeup-enable word holds.
- R6: A source with status 1, mask 0 and wakeup enable 1 raises the wakeup request of an idle core, while the interrupt request stays low.
- R7: Bit positions at or above the number of sources read as 0 in every word and ignore writes.
- R8: The wakeup-enable word can be written while the core is idle. The wakeup request follows the new value one edge after the write edge.
- R9: When the idle input falls while a wakeup is pending, the wakeup request drops one edge later.
- R10: A read from an offset other than 0, 4 or 8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Peripheral interrupt levels |
| core_idle_i | input | 1 | Core reports it is idle |
| bus_wr_en_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_req_o | output | 1 | Core interrupt request |
| wake_req_o | output | 1 | Wakeup request to power management |

## Verification
Two functions can fall in the same clock cycle: a write to the wakeup-enable word, and the capture of the wakeup request for an idle core with a matching status bit. The bench sets up a pending wakeup and then clears the enable with a write. It expects the request to stay high at the write edge and to fall at the next edge. It also sweeps every status pattern against several mask and enable words, with the idle input both low and high. In each case the interrupt and wakeup outcomes are judged together, so a masked source that still wakes the core is told apart from one that does neither.

// File: rtl/iwa_pkg.sv
package iwa_pkg;
  localparam int unsigned OFS_MASK = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_WAKE = 8;

  // any position where both words carry a 1
  function automatic logic any_hit(input logic [31:0] a, input logic [31:0] b);
    return |(a & b);
  endfunction

  // ones in the implemented positions
  function automatic logic [31:0] impl_bits(input int unsigned n);
    logic [31:0] r;
    r = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/iwa_sync.sv
module iwa_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/iwa_regfile.sv
module iwa_regfile
  import iwa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] wen_o,
  output logic [31:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(OFS_WAKE);

  logic sel_mask, sel_stat, sel_wake;
  assign sel_mask = (addr_i == A_MASK);
  assign sel_stat = (addr_i == A_STAT);
  assign sel_wake = (addr_i == A_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      wen_o  <= '1;
    end else if (wr_en_i) begin
      if (sel_mask) mask_o <= wdata_i[NUM_SRC-1:0];
      if (sel_wake) wen_o  <= wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_mask)      rdata_o = 32'(mask_o);
    else if (sel_stat) rdata_o = 32'(status_i);
    else if (sel_wake) rdata_o = 32'(wen_o);
  end
endmodule

// File: rtl/iwa_combine.sv
module iwa_combine
  import iwa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] wen_i,
  input  logic               idle_i,
  output logic               wake_hit_o,
  output logic               irq_o,
  output logic               wake_o
);
  assign irq_o      = any_hit(32'(status_i), 32'(mask_i));
  assign wake_hit_o = idle_i && any_hit(32'(status_i), 32'(wen_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_o <= 1'b0;
    else        wake_o <= wake_hit_o;
  end
endmodule

// File: rtl/irq_wake_agg.sv
module irq_wake_agg
  import iwa_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               core_idle_i,
  input  logic               bus_wr_en_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_req_o,
  output logic               wake_req_o
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] wen_q;
  logic               wake_hit;

  iwa_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (status_q)
  );

  iwa_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (bus_wr_en_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (status_q),
    .mask_o   (mask_q),
    .wen_o    (wen_q),
    .rdata_o  (bus_rdata_o)
  );

  iwa_combine #(.NUM_SRC(NUM_SRC)) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_i   (status_q),
    .mask_i     (mask_q),
    .wen_i      (wen_q),
    .idle_i     (core_idle_i),
    .wake_hit_o (wake_hit),
    .irq_o      (irq_req_o),
    .wake_o     (wake_req_o)
  );
endmodule

// File: rtl/irq_wake_agg_chk.sv
module irq_wake_agg_chk
  import iwa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_idle_i,
  input logic               bus_wr_en_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [31:0]        bus_rdata_o,
  input logic               irq_req_o,
  input logic               wake_req_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] wen_q
);
  localparam logic [31:0] IMPL = impl_bits(NUM_SRC);

  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_idle_i && |(status_q & wen_q)) |=> wake_req_o); // R4
  AST_WAKE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle_i |=> !wake_req_o); // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_req_o); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en_i && bus_addr_i == ADDR_W'(OFS_MASK)) |=> $stable(mask_q)); // R3
  AST_WEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en_i && bus_addr_i == ADDR_W'(OFS_WAKE)) |=> $stable(wen_q)); // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_o & ~IMPL) == 32'h0); // R7
endmodule

bind irq_wake_agg irq_wake_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_idle_i (core_idle_i),
  .bus_wr_en_i (bus_wr_en_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_req_o   (irq_req_o),
  .wake_req_o  (wake_req_o),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .wen_q       (wen_q)
);

// File: tb/irq_wake_agg_bench.sv
module irq_wake_agg_bench;
  localparam int unsigned N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          idle = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, wake;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_wake_agg #(.NUM_SRC(N), .ADDR_W(4), .SYNC_STAGES(2)) u_irq_wake_agg (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .core_idle_i (idle),
    .bus_wr_en_i (wr_en),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_req_o   (irq),
    .wake_req_o  (wake)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] mlist [4];
    logic [31:0] wlist [4];
    mlist = '{32'h00, 32'h3F, 32'h2A, 32'h01};
    wlist = '{32'h3F, 32'h00, 32'h15, 32'h20};

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(4'd0, rd); check("R1 mask", rd, 32'h0);
    bus_read(4'd8, rd); check("R1 wen", rd, ALL);
    bus_read(4'd4, rd); check("R1 status", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wake", {31'b0, wake}, 32'h0);

    // R7 unimplemented bits
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_read(4'd0, rd); check("R7 mask upper", rd, ALL);
    bus_write(4'd8, 32'hFFFF_FFC0);
    bus_read(4'd8, rd); check("R7 wen upper", rd, 32'h0);
    bus_write(4'd0, 32'h0);
    bus_write(4'd8, ALL);

    // R10 unmapped offset
    bus_read(4'd12, rd); check("R10 unmapped", rd, 32'h0);

    // R2 status is read only
    src = 6'h15;
    settle();
    bus_write(4'd4, 32'h0);
    bus_read(4'd4, rd); check("R2 status write ignored", rd, 32'h15);

    // R3 R4 R5 sweep
    for (int mi = 0; mi < 4; mi++) begin
      for (int wi = 0; wi < 4; wi++) begin
        bus_write(4'd0, mlist[mi]);
        bus_write(4'd8, wlist[wi]);
        for (int s = 0; s < 64; s++) begin
          for (int id = 0; id < 2; id++) begin
            src = N'(s);
            idle = id[0];
            settle();
            bus_read(4'd4, rd); check("R2 status", rd, 32'(s));
            check("R3 irq", {31'b0, irq}, {31'b0, ((32'(s) & mlist[mi]) != 0)});
            check("R4 R5 wake", {31'b0, wake},
                  {31'b0, (id == 1) && ((32'(s) & wlist[wi]) != 0)});
          end
        end
      end
    end

    // R6 masked source wakes but no irq
    bus_write(4'd0, 32'h0);
    bus_write(4'd8, 32'h01);
    src = 6'h01; idle = 1'b1;
    settle();
    check("R6 wake", {31'b0, wake}, 32'h1);
    check("R6 irq", {31'b0, irq}, 32'h0);

    // R9 idle drop clears wake one edge later
    idle = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 wake drop", {31'b0, wake}, 32'h0);
    // R4 one-edge latency on idle rise
    idle = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 wake latency", {31'b0, wake}, 32'h1);

    // R8 write wen while idle and pending
    bus_write(4'd8, 32'h0);
    check("R8 wake at write edge", {31'b0, wake}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R8 wake after write", {31'b0, wake}, 32'h0);
    bus_read(4'd8, rd); check("R8 wen readback", rd, 32'h0);
    bus_write(4'd8, 32'h01);
    check("R8 wake re-enable edge", {31'b0, wake}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 wake re-enabled", {31'b0, wake}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule